// File: doc/BRIEF.md
# Interrupt Active-State Register Window

This block holds the active flag of every interrupt in a multi-CPU interrupt distributor. It answers a byte-wide register access bus through two address windows. Writing a 1 bit to the set window marks the interrupt active, and writing a 1 bit to the clear window marks it inactive. A read of either window returns the current flags. Interrupts below the internal boundary (32) have one flag per CPU, and the access's CPU index selects which copy is used. Interrupts at or above the boundary have one flag that all CPUs share.

Non-secure accesses are filtered by each interrupt's group bit when the security extension is enabled. The windows exist only when the revision parameter is 2. An access to a byte past the implemented interrupts, or to a build with any other revision, returns an error.

The register bus has no back-pressure. Every strobe is accepted and completes in the cycle it is presented. Read data and the error flag are combinational in that cycle, and writes take effect at the next rising clock edge. Only the active flags change. No other distributor state is touched.

Top module: `irq_active_regs`

## Requirements
- R1: Offsets 0x300–0x37F form the set window (offset bit 7 = 0) and offsets 0x380–0x3FF form the clear window (offset bit 7 = 1). An access to an offset outside 0x300–0x3FF gives err = 0 and rdata = 0, and changes no flag.
- R2: Offset bits [6:0] give a byte number k, which covers interrupts 8k to 8k+7. Data bit i maps to interrupt 8k+i.
- R3: A write of a 1 bit in the set window makes that interrupt active. A write of a 1 bit in the clear window makes it inactive. A 0 bit leaves the flag unchanged.
- R4: With sec_ext_en = 1 and acc_secure = 0, write bits for group-0 interrupts (irq_group bit = 0) are ignored. Group-1 bits in the same byte still take effect.
- R5: For interrupts 0–31, a write updates only the copy of the CPU given by acc_cpu. For interrupts 32 and above, one shared flag is updated and all CPUs see it.
- R6: If 8k is at or above NUM_IRQ, the access raises err, rdata is 0 and no flag changes.
- R7: When REVISION is not 2, every access to 0x300–0x3FF raises err and changes no flag.
- R8: A read of either window returns the eight flags of byte k as seen by acc_cpu. With sec_ext_en = 1 and acc_secure = 0, group-0 interrupts read as 0. A write returns rdata = 0.
- R9: Reset clears every flag. err and rdata are valid in the same cycle as acc_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 12 | Byte offset in the distributor space |
| acc_wdata | input | 8 | Write data, one bit per interrupt |
| acc_cpu | input | CPU_W | Index of the requesting CPU |
| acc_secure | input | 1 | 1 = secure access |
| sec_ext_en | input | 1 | Security extension enable |
| irq_group | input | NUM_IRQ | Group bit per interrupt (0 = group 0) |
| acc_rdata | output | 8 | Read data (combinational) |
| acc_err | output | 1 | Error response (combinational) |

## Verification
The assertions check the following on every cycle: an error comes only from a window access, and an errored access leaves every flag unchanged. A set write never clears a flag, and a clear write never sets one. Writes of zero data, and cycles without a write, leave the state unchanged. A build with a revision other than 2 flags every window access. Behaviour that depends on which bits land where can only be shown by the bench scenarios, which compare read-back values against a reference model. These cover the bit-to-interrupt mapping, per-CPU banking against shared flags, group filtering of mixed bytes and read masking.

// File: rtl/irq_active_pkg.sv
package irq_active_pkg;
  localparam logic [3:0] WIN_PAGE   = 4'h3;
  localparam int         NUM_INT_DF = 32;
  localparam int         BYTE_BITS  = 7;
  typedef logic [BYTE_BITS-1:0] byte_idx_t;
endpackage

// File: rtl/irq_active_decode.sv
module irq_active_decode
  import irq_active_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int REVISION = 2
) (
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [11:0]        acc_offset,
  input  logic [7:0]         acc_wdata,
  input  logic               acc_secure,
  input  logic               sec_ext_en,
  input  logic [NUM_IRQ-1:0] irq_group,
  output logic               acc_err,
  output logic               rd_ok,
  output byte_idx_t          byte_idx,
  output logic [NUM_IRQ-1:0] allowed,
  output logic [NUM_IRQ-1:0] set_vec,
  output logic [NUM_IRQ-1:0] clr_vec
);
  localparam bit REV_OK = (REVISION == 2);

  logic       in_win;
  logic [9:0] first_irq;
  logic       range_ok;
  logic       acc_ok;
  logic       wr_ok;

  assign in_win    = (acc_offset[11:8] == WIN_PAGE);
  assign byte_idx  = acc_offset[6:0];
  assign first_irq = {byte_idx, 3'b000};
  assign range_ok  = (int'(first_irq) < NUM_IRQ);
  assign acc_ok    = acc_valid && in_win && REV_OK && range_ok;
  assign acc_err   = acc_valid && in_win && !(REV_OK && range_ok);
  assign rd_ok     = acc_ok && !acc_write;
  assign wr_ok     = acc_ok && acc_write;

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_bit
    localparam int BYT = n / 8;
    localparam int BIT = n % 8;
    logic hit;
    assign allowed[n] = !(sec_ext_en && !acc_secure && !irq_group[n]);
    assign hit        = wr_ok && (byte_idx == BYTE_BITS'(BYT)) &&
                        acc_wdata[BIT] && allowed[n];
    assign set_vec[n] = hit && !acc_offset[7];
    assign clr_vec[n] = hit &&  acc_offset[7];
  end
endmodule

// File: rtl/irq_active_store.sv
module irq_active_store #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int NUM_INT = 32,
  parameter int CPU_W   = 1,
  parameter int SHR_N   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CPU_W-1:0]                cpu,
  input  logic [NUM_IRQ-1:0]              set_vec,
  input  logic [NUM_IRQ-1:0]              clr_vec,
  output logic [NUM_CPU-1:0][NUM_INT-1:0] priv_q,
  output logic [SHR_N-1:0]                shr_q
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) priv_q[c] <= '0;
      else if (int'(cpu) == c)
        priv_q[c] <= (priv_q[c] | set_vec[NUM_INT-1:0]) & ~clr_vec[NUM_INT-1:0];
    end
  end

  if (NUM_IRQ > NUM_INT) begin : g_shared
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shr_q <= '0;
      else shr_q <= (shr_q | set_vec[NUM_IRQ-1:NUM_INT]) & ~clr_vec[NUM_IRQ-1:NUM_INT];
    end
  end else begin : g_no_shared
    assign shr_q = '0;
  end
endmodule

// File: rtl/irq_active_readmux.sv
module irq_active_readmux
  import irq_active_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int NUM_INT = 32,
  parameter int CPU_W   = 1,
  parameter int SHR_N   = 32
) (
  input  logic [NUM_CPU-1:0][NUM_INT-1:0] priv_q,
  input  logic [SHR_N-1:0]                shr_q,
  input  logic [CPU_W-1:0]                cpu,
  input  logic                            rd_ok,
  input  byte_idx_t                       byte_idx,
  input  logic [NUM_IRQ-1:0]              allowed,
  output logic [7:0]                      rdata
);
  logic [NUM_INT-1:0] own_priv;
  logic [NUM_IRQ-1:0] view;
  logic [1023:0]      view_pad;

  always_comb begin
    own_priv = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (int'(cpu) == c) own_priv = priv_q[c];
  end

  if (NUM_IRQ > NUM_INT) begin : g_view_sh
    assign view = {shr_q[NUM_IRQ-NUM_INT-1:0], own_priv} & allowed;
  end else begin : g_view_pr
    assign view = own_priv[NUM_IRQ-1:0] & allowed;
  end

  always_comb begin
    view_pad = '0;
    view_pad[NUM_IRQ-1:0] = view;
    rdata = '0;
    for (int i = 0; i < 8; i++)
      if (rd_ok) rdata[i] = view_pad[{byte_idx, 3'(i)}];
  end
endmodule

// File: rtl/irq_active_regs.sv
module irq_active_regs
  import irq_active_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_CPU  = 2,
  parameter int REVISION = 2,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [11:0]        acc_offset,
  input  logic [7:0]         acc_wdata,
  input  logic [CPU_W-1:0]   acc_cpu,
  input  logic               acc_secure,
  input  logic               sec_ext_en,
  input  logic [NUM_IRQ-1:0] irq_group,
  output logic [7:0]         acc_rdata,
  output logic               acc_err
);
  localparam int NUM_INT = NUM_INT_DF;
  localparam int SHR_N   = (NUM_IRQ > NUM_INT) ? NUM_IRQ - NUM_INT : 1;
  localparam int ST_W    = NUM_CPU * NUM_INT + SHR_N;

  logic                            rd_ok;
  byte_idx_t                       byte_idx;
  logic [NUM_IRQ-1:0]              allowed, set_vec, clr_vec;
  logic [NUM_CPU-1:0][NUM_INT-1:0] priv_q;
  logic [SHR_N-1:0]                shr_q;

  irq_active_decode #(.NUM_IRQ(NUM_IRQ), .REVISION(REVISION)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
    .acc_wdata(acc_wdata), .acc_secure(acc_secure), .sec_ext_en(sec_ext_en),
    .irq_group(irq_group), .acc_err(acc_err), .rd_ok(rd_ok),
    .byte_idx(byte_idx), .allowed(allowed), .set_vec(set_vec), .clr_vec(clr_vec)
  );

  irq_active_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_INT(NUM_INT),
                     .CPU_W(CPU_W), .SHR_N(SHR_N)) u_store (
    .clk(clk), .rst_n(rst_n), .cpu(acc_cpu), .set_vec(set_vec),
    .clr_vec(clr_vec), .priv_q(priv_q), .shr_q(shr_q)
  );

  irq_active_readmux #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_INT(NUM_INT),
                       .CPU_W(CPU_W), .SHR_N(SHR_N)) u_rd (
    .priv_q(priv_q), .shr_q(shr_q), .cpu(acc_cpu), .rd_ok(rd_ok),
    .byte_idx(byte_idx), .allowed(allowed), .rdata(acc_rdata)
  );

  logic [ST_W-1:0] st;
  logic            win_acc, good_wr;
  assign st      = {shr_q, priv_q};
  assign win_acc = acc_valid && (acc_offset[11:8] == WIN_PAGE);
  assign good_wr = acc_valid && acc_write && !acc_err;

  // R1
  err_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> win_acc);
  // R6
  err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> $stable(st));
  // R3
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(st));
  // R3
  zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_wdata == 8'h00) |=> $stable(st));
  // R3
  set_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && !acc_offset[7]) |=> ((st & $past(st)) == $past(st)));
  // R3
  clr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && acc_offset[7]) |=> ((st | $past(st)) == $past(st)));
  // R7
  rev_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REVISION != 2 && win_acc) |-> acc_err);
endmodule

// File: tb/tb_irq_active_regs.sv
`timescale 1ns/1ps
module tb_irq_active_regs;
  localparam int NIRQ = 64;
  localparam int NCPU = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_secure = 1, sec_ext_en = 0;
  logic [11:0] acc_offset = '0;
  logic [7:0]  acc_wdata = '0;
  logic [0:0]  acc_cpu = '0;
  logic [NIRQ-1:0] irq_group = '0;
  logic [7:0] rdata, rdata1;
  logic err, err1;

  int checks = 0, failures = 0, cycles = 0;
  bit mp[NCPU][32];
  bit ms[NIRQ];

  always #2 clk = ~clk;

  irq_active_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(2)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu),
    .acc_secure(acc_secure), .sec_ext_en(sec_ext_en), .irq_group(irq_group),
    .acc_rdata(rdata), .acc_err(err));

  irq_active_regs #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(1)) dut_v1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_cpu(acc_cpu),
    .acc_secure(acc_secure), .sec_ext_en(sec_ext_en), .irq_group(irq_group),
    .acc_rdata(rdata1), .acc_err(err1));

  function automatic bit m_allowed(int n, bit sec);
    return !(sec_ext_en && !sec && !irq_group[n]);
  endfunction

  function automatic bit m_inwin(logic [11:0] off);
    return off[11:8] == 4'h3;
  endfunction

  function automatic bit m_err(logic [11:0] off);
    return m_inwin(off) && (int'(off[6:0]) * 8 >= NIRQ);
  endfunction

  function automatic logic [7:0] m_read(logic [11:0] off, int cpu, bit sec);
    logic [7:0] r = '0;
    if (!m_inwin(off) || m_err(off)) return r;
    for (int i = 0; i < 8; i++) begin
      int n = int'(off[6:0]) * 8 + i;
      bit v = (n < 32) ? mp[cpu][n] : ms[n];
      r[i] = v && m_allowed(n, sec);
    end
    return r;
  endfunction

  task automatic m_write(logic [11:0] off, logic [7:0] d, int cpu, bit sec);
    if (!m_inwin(off) || m_err(off)) return;
    for (int i = 0; i < 8; i++) begin
      int n = int'(off[6:0]) * 8 + i;
      if (d[i] && m_allowed(n, sec)) begin
        if (n < 32) mp[cpu][n] = !off[7];
        else ms[n] = !off[7];
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; compares rdata/err of both builds, then updates the model
  task automatic acc(bit wr, logic [11:0] off, logic [7:0] d, int cpu, bit sec, string req);
    logic [7:0] er;
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_offset = off; acc_wdata = d;
    acc_cpu = 1'(cpu); acc_secure = sec;
    #1;
    er = wr ? 8'h00 : m_read(off, cpu, sec);
    chk({req, " rdata"}, rdata, er);
    chk({req, " err"}, {7'd0, err}, {7'd0, m_err(off)});
    // R7: the revision-1 build treats the whole window as reserved
    chk("R7 err", {7'd0, err1}, {7'd0, m_inwin(off)});
    chk("R7 rdata", rdata1, 8'h00);
    @(posedge clk); #1;
    acc_valid = 0;
    if (wr) m_write(off, d, cpu, sec);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9: all flags clear after reset, for each CPU
    for (int b = 0; b < 8; b++) acc(0, 12'h300 + 12'(b), 8'h00, b % 2, 1, "R9 reset");
    // R2/R3: set single bits, read through clear window
    acc(1, 12'h301, 8'h81, 0, 1, "R2 set");
    acc(0, 12'h381, 8'h00, 0, 1, "R2 read");
    // R5: banked byte invisible to other cpu
    acc(0, 12'h301, 8'h00, 1, 1, "R5 banked");
    // R5: shared byte seen by both cpus
    acc(1, 12'h305, 8'h3C, 1, 1, "R5 shared set");
    acc(0, 12'h305, 8'h00, 0, 1, "R5 shared read");
    // R3: zero data no effect, clear one bit
    acc(1, 12'h385, 8'h00, 0, 1, "R3 zero");
    acc(1, 12'h385, 8'h04, 0, 1, "R3 clear");
    acc(0, 12'h305, 8'h00, 1, 1, "R3 readback");
    // R4/R8: mixed-group byte under non-secure access
    sec_ext_en = 1; irq_group = 64'h00F0_0000_0000_0000;
    acc(1, 12'h306, 8'hFF, 0, 0, "R4 filter");
    acc(0, 12'h306, 8'h00, 0, 1, "R4 secure view");
    acc(0, 12'h306, 8'h00, 0, 0, "R8 ns view");
    sec_ext_en = 0;
    // R6: first interrupt out of range
    acc(1, 12'h308, 8'hFF, 0, 1, "R6 range");
    acc(0, 12'h37F, 8'h00, 0, 1, "R6 range rd");
    // R1: outside window no error, no data
    acc(1, 12'h2FF, 8'hFF, 0, 1, "R1 outside");
    acc(0, 12'h400, 8'h00, 0, 1, "R1 outside rd");
    // random mix, model checks R2 R3 R4 R5 R8
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] off;
      int r = int'($urandom % 20);
      if (k % 50 == 0) begin
        sec_ext_en = 1'($urandom);
        irq_group = {$urandom, $urandom};
      end
      if (r == 0) off = 12'h200 + 12'($urandom % 12'h300);
      else off = 12'h300 + (($urandom % 2) ? 12'h080 : 12'h000) + 12'($urandom % 10);
      acc(1'($urandom), off, 8'($urandom), int'($urandom % 2), 1'($urandom), "R3R5R8 random");
    end
    // R9: reset mid-run clears flags
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    for (int c = 0; c < NCPU; c++) for (int n = 0; n < 32; n++) mp[c][n] = 0;
    for (int n = 0; n < NIRQ; n++) ms[n] = 0;
    sec_ext_en = 0;
    for (int b = 0; b < 8; b++) acc(0, 12'h380 + 12'(b), 8'h00, 1, 1, "R9 re-reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule